// File: doc/BRIEF.md
# UART Interrupt Arbiter and Modem Status Unit

This block produces the interrupt request of one UART channel, the identification code that tells software which source is behind it, and the modem status byte. The serial core reports line errors, received bytes and the state of the transmit holding register. Four active-low modem inputs are synchronised, and changes on them are held as sticky delta flags. The modem outputs are driven from the modem control bits.

Four interrupt classes are latched separately, and each one has its own clear action. A per-class enable vector masks them. A fixed priority encoder then selects the class that is reported. Reading the status registers, reading the identification code or writing the transmit holding register clears the matching class. In loopback mode the modem status follows the modem control bits instead of the pins.

Top module: `uart_irq_unit`

## Requirements
- R1: After reset `irq_o` is 0, `iir_o` is 0x01, `msr_o` is 0x00 while all modem pins are high, and the modem outputs are high.
- R2: `dtr_no`, `rts_no` and `op2_no` are the inverses of `mcr_i[0]`, `mcr_i[1]` and `mcr_i[3]`, in every mode.
- R3: Outside loopback (`mcr_i[4]`=0), `msr_o[4]`, `msr_o[5]`, `msr_o[6]` and `msr_o[7]` report the inverted levels of `cts_ni`, `dsr_ni`, `ri_ni` and `cd_ni`. They follow a pin change within SYNC_STAGES+1 clocks.
- R4: With `mcr_i[4]`=1, `msr_o[7:4]` equals {`mcr_i[3]`, `mcr_i[2]`, `mcr_i[0]`, `mcr_i[1]`}, and the pins are ignored.
- R5: Any change of the reported CTS, DSR or CD level sets `msr_o[0]`, `msr_o[1]` or `msr_o[3]` respectively.
- R6: `msr_o[2]` is set only when the reported RI level falls from 1 to 0. A rise of RI leaves it unchanged.
- R7: A one-cycle `msr_rd_i` clears `msr_o[3:0]`. A delta that arrives in the same cycle survives the clear.
- R8: A nonzero `lsr_err_i` pulse latches a line-status source. With `ier_i[2]`=1 it is reported as `iir_o`=0x06. `lsr_rd_i` clears it.
- R9: An `rx_load_i` pulse latches a receive source. With `ier_i[0]`=1 it is reported as 0x04. `rhr_rd_i` clears it.
- R10: A rising `thr_empty_i` latches a transmit source. With `ier_i[1]`=1 it is reported as 0x02. `thr_wr_i` clears it. `iir_rd_i` clears it only while `iir_o` is 0x02.
- R11: A rise of `ier_i[1]` while `thr_empty_i` is 1 latches the transmit source.
- R12: Priority from highest to lowest is line, receive, transmit, modem. A nonzero `msr_o[3:0]` with `ier_i[3]`=1 is reported as 0x00. `irq_o` is 1 exactly when `iir_o` is not 0x01.
- R13: A source whose enable bit is 0 does not raise `irq_o`, but it stays latched and is reported once the bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ier_i | input | 4 | Enables: 0 receive, 1 transmit, 2 line, 3 modem |
| mcr_i | input | 5 | 0 DTR, 1 RTS, 2 OUT1, 3 OUT2, 4 loopback |
| cts_ni | input | 1 | Clear-to-send pin, active low |
| dsr_ni | input | 1 | Data-set-ready pin, active low |
| ri_ni | input | 1 | Ring indicator pin, active low |
| cd_ni | input | 1 | Carrier detect pin, active low |
| lsr_err_i | input | 4 | Line error pulses (overrun, parity, framing, break) |
| rx_load_i | input | 1 | Byte loaded into receive holding register |
| thr_empty_i | input | 1 | Transmit holding register empty level |
| lsr_rd_i | input | 1 | Line status read strobe |
| rhr_rd_i | input | 1 | Receive holding register read strobe |
| thr_wr_i | input | 1 | Transmit holding register write strobe |
| iir_rd_i | input | 1 | Identification register read strobe |
| msr_rd_i | input | 1 | Modem status read strobe |
| irq_o | output | 1 | Interrupt request |
| iir_o | output | 8 | Interrupt identification code |
| msr_o | output | 8 | Modem status: deltas [3:0], levels [7:4] |
| dtr_no | output | 1 | Data-terminal-ready pin, active low |
| rts_no | output | 1 | Request-to-send pin, active low |
| op2_no | output | 1 | General output 2, active low |

## Verification
The bench drives an RI leading edge and then a trailing edge. A detector that fires on both edges would set the ring delta too early. It also reads the identification code while the receive source outranks a pending transmit source. A design that cleared the transmit source on any identification read would then report 0x01 instead of 0x02 after the receive byte is read. Re-enabling the transmit interrupt while the holding register stays empty must report 0x02 at once, and a design without enable-edge detection would miss it. Loopback transitions check the pin-to-control-bit mapping and the resulting deltas. Latched sources that are masked must stay invisible on `irq_o` until they are enabled.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int MDM_N   = 4;
  localparam int MDM_CTS = 0;
  localparam int MDM_DSR = 1;
  localparam int MDM_RI  = 2;
  localparam int MDM_CD  = 3;
  localparam int LSR_ERR_W = 4;
  localparam int IER_W = 4;
  localparam int MCR_W = 5;

  typedef enum logic [7:0] {
    IID_NONE = 8'h01,
    IID_LINE = 8'h06,
    IID_RXD  = 8'h04,
    IID_TXE  = 8'h02,
    IID_MDM  = 8'h00
  } iid_e;
endpackage

// File: rtl/uart_irq_sync.sv
module uart_irq_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) chain_q[i] <= RST_VAL;
    end else begin
      chain_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/uart_msr_track.sv
module uart_msr_track
  import uart_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [MDM_N-1:0] lvl_i,   // asserted levels, index per MDM_* constants
  input  logic             rd_i,
  output logic [MDM_N-1:0] delta_o,
  output logic [7:0]       msr_o
);
  logic [MDM_N-1:0] lvl_q, delta_q, hit;

  for (genvar g = 0; g < MDM_N; g++) begin : g_hit
    if (g == MDM_RI) begin : g_trail
      assign hit[g] = lvl_q[g] & ~lvl_i[g];
    end else begin : g_any
      assign hit[g] = lvl_q[g] ^ lvl_i[g];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q   <= '0;
      delta_q <= '0;
    end else begin
      lvl_q   <= lvl_i;
      delta_q <= (rd_i ? '0 : delta_q) | hit;  // new change beats the clear
    end
  end

  assign delta_o = delta_q;
  assign msr_o   = {lvl_i, delta_q};
endmodule

// File: rtl/uart_irq_src.sv
module uart_irq_src
  import uart_irq_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [IER_W-1:0]     ier_i,
  input  logic [LSR_ERR_W-1:0] lsr_err_i,
  input  logic                 rx_load_i,
  input  logic                 thr_empty_i,
  input  logic                 lsr_rd_i,
  input  logic                 rhr_rd_i,
  input  logic                 thr_wr_i,
  input  logic                 iir_rd_i,
  input  logic                 mdm_any_i,
  output logic                 irq_o,
  output iid_e                 iid_o
);
  logic [LSR_ERR_W-1:0] err_q;
  logic rx_q, tx_q, empty_q, tx_en_q;
  logic ls_pend, rx_pend, tx_pend, ms_pend, tx_set, tx_clr;

  assign tx_set = (thr_empty_i & ~empty_q) | (thr_empty_i & ier_i[1] & ~tx_en_q);
  assign tx_clr = thr_wr_i | (iir_rd_i && iid_o == IID_TXE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q   <= '0;
      rx_q    <= 1'b0;
      tx_q    <= 1'b0;
      empty_q <= 1'b0;
      tx_en_q <= 1'b0;
    end else begin
      empty_q <= thr_empty_i;
      tx_en_q <= ier_i[1];
      err_q   <= (lsr_rd_i ? '0 : err_q) | lsr_err_i;
      rx_q    <= (rx_q & ~rhr_rd_i) | rx_load_i;
      tx_q    <= (tx_q & ~tx_clr) | tx_set;
    end
  end

  assign ls_pend = (|err_q) & ier_i[2];
  assign rx_pend = rx_q & ier_i[0];
  assign tx_pend = tx_q & ier_i[1];
  assign ms_pend = mdm_any_i & ier_i[3];

  always_comb begin
    if (ls_pend)      iid_o = IID_LINE;
    else if (rx_pend) iid_o = IID_RXD;
    else if (tx_pend) iid_o = IID_TXE;
    else if (ms_pend) iid_o = IID_MDM;
    else              iid_o = IID_NONE;
  end

  assign irq_o = ls_pend | rx_pend | tx_pend | ms_pend;
endmodule

// File: rtl/uart_irq_unit.sv
module uart_irq_unit
  import uart_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [IER_W-1:0]     ier_i,
  input  logic [MCR_W-1:0]     mcr_i,
  input  logic                 cts_ni,
  input  logic                 dsr_ni,
  input  logic                 ri_ni,
  input  logic                 cd_ni,
  input  logic [LSR_ERR_W-1:0] lsr_err_i,
  input  logic                 rx_load_i,
  input  logic                 thr_empty_i,
  input  logic                 lsr_rd_i,
  input  logic                 rhr_rd_i,
  input  logic                 thr_wr_i,
  input  logic                 iir_rd_i,
  input  logic                 msr_rd_i,
  output logic                 irq_o,
  output logic [7:0]           iir_o,
  output logic [7:0]           msr_o,
  output logic                 dtr_no,
  output logic                 rts_no,
  output logic                 op2_no
);
  logic [MDM_N-1:0] pin_n, pin_sync_n, pin_lvl, loop_lvl, lvl, delta;
  iid_e iid;

  assign pin_n = {cd_ni, ri_ni, dsr_ni, cts_ni};

  if (SYNC_STAGES > 0) begin : g_sync
    uart_irq_sync #(.WIDTH(MDM_N), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (pin_n),
      .q_o   (pin_sync_n)
    );
  end else begin : g_nosync
    assign pin_sync_n = pin_n;
  end

  assign pin_lvl  = ~pin_sync_n;
  assign loop_lvl = {mcr_i[3], mcr_i[2], mcr_i[0], mcr_i[1]};
  assign lvl      = mcr_i[4] ? loop_lvl : pin_lvl;

  uart_msr_track u_msr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (lvl),
    .rd_i   (msr_rd_i),
    .delta_o(delta),
    .msr_o  (msr_o)
  );

  uart_irq_src u_src (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ier_i      (ier_i),
    .lsr_err_i  (lsr_err_i),
    .rx_load_i  (rx_load_i),
    .thr_empty_i(thr_empty_i),
    .lsr_rd_i   (lsr_rd_i),
    .rhr_rd_i   (rhr_rd_i),
    .thr_wr_i   (thr_wr_i),
    .iir_rd_i   (iir_rd_i),
    .mdm_any_i  (|delta),
    .irq_o      (irq_o),
    .iid_o      (iid)
  );

  assign iir_o  = iid;
  assign dtr_no = ~mcr_i[0];
  assign rts_no = ~mcr_i[1];
  assign op2_no = ~mcr_i[3];
endmodule

// File: rtl/uart_irq_unit_chk.sv
module uart_irq_unit_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ls_en_i,
  input logic       tx_en_i,
  input logic [3:0] lsr_err_i,
  input logic       rx_load_i,
  input logic       rhr_rd_i,
  input logic       thr_wr_i,
  input logic       thr_empty_i,
  input logic       msr_rd_i,
  input logic [7:0] iir_o,
  input logic [7:0] msr_o
);
  AST_LINE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lsr_err_i != 4'h0) && ls_en_i |=> (!ls_en_i || iir_o == 8'h06)); // R8

  AST_RX_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rhr_rd_i && !rx_load_i |=> iir_o != 8'h04); // R9

  AST_TX_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_wr_i && $stable(thr_empty_i) && $stable(tx_en_i) |=> iir_o != 8'h02); // R10

  AST_DELTA_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msr_rd_i && $stable(msr_o[7:4]) |=> msr_o[3:0] == 4'h0); // R7

  AST_RI_LEAD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(msr_o[6]) && msr_rd_i |=> !msr_o[2]); // R6
endmodule

bind uart_irq_unit uart_irq_unit_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ls_en_i    (ier_i[2]),
  .tx_en_i    (ier_i[1]),
  .lsr_err_i  (lsr_err_i),
  .rx_load_i  (rx_load_i),
  .rhr_rd_i   (rhr_rd_i),
  .thr_wr_i   (thr_wr_i),
  .thr_empty_i(thr_empty_i),
  .msr_rd_i   (msr_rd_i),
  .iir_o      (iir_o),
  .msr_o      (msr_o)
);

// File: tb/uart_irq_unit_tb.sv
module uart_irq_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [3:0] ier = '0;
  logic [4:0] mcr = '0;
  logic cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, cd_n = 1'b1;
  logic [3:0] lsr_err = '0;
  logic [5:0] strb = '0;  // 0 msr_rd,1 lsr_rd,2 rhr_rd,3 iir_rd,4 thr_wr,5 rx_load
  logic thr_empty = 1'b0;

  logic irq;
  logic [7:0] iir, msr;
  logic dtr_n, rts_n, op2_n;

  uart_irq_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ier_i(ier), .mcr_i(mcr),
    .cts_ni(cts_n), .dsr_ni(dsr_n), .ri_ni(ri_n), .cd_ni(cd_n),
    .lsr_err_i(lsr_err), .rx_load_i(strb[5]), .thr_empty_i(thr_empty),
    .lsr_rd_i(strb[1]), .rhr_rd_i(strb[2]), .thr_wr_i(strb[4]),
    .iir_rd_i(strb[3]), .msr_rd_i(strb[0]),
    .irq_o(irq), .iir_o(iir), .msr_o(msr),
    .dtr_no(dtr_n), .rts_no(rts_n), .op2_no(op2_n)
  );

  typedef struct {
    string      req;
    logic [7:0] iir;
    logic [7:0] msr;
    logic [2:0] outs;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input logic [5:0] m, input logic [3:0] err);
    @(negedge clk);
    strb = m;
    lsr_err = err;
    @(negedge clk);
    strb = '0;
    lsr_err = '0;
  endtask

  task automatic expect_now(input string req, input logic [7:0] e_iir, input logic [7:0] e_msr);
    exp_t it;
    it.req  = req;
    it.iir  = e_iir;
    it.msr  = e_msr;
    it.outs = {~mcr[1], ~mcr[0], ~mcr[3]};
    exp_q.push_back(it);
    #0.1;
  endtask

  initial begin : monitor
    forever begin
      exp_t it;
      wait (exp_q.size() != 0);
      it = exp_q.pop_front();
      checks++;
      if (iir !== it.iir || irq !== ~it.iir[0] || msr !== it.msr ||
          {rts_n, dtr_n, op2_n} !== it.outs) begin
        errors++;
        $display("FAIL %s: iir=%h irq=%b msr=%h outs=%b expected iir=%h irq=%b msr=%h outs=%b",
                 it.req, iir, irq, msr, {rts_n, dtr_n, op2_n},
                 it.iir, ~it.iir[0], it.msr, it.outs);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    step(3);
    rst_n = 1'b1;
    step(1);
    expect_now("R1 reset", 8'h01, 8'h00);
    mcr = 5'b01011;
    step(1);
    expect_now("R2 outputs", 8'h01, 8'h00);
    mcr = '0;

    // modem inputs, interrupt masked (R13)
    cts_n = 1'b0; step(4);
    expect_now("R3 R5 R13 cts", 8'h01, 8'h11);
    ier = 4'h8; step(1);
    expect_now("R12 modem source", 8'h00, 8'h11);
    strobe(6'b000001, 4'h0);
    expect_now("R7 read clears", 8'h01, 8'h10);
    ri_n = 1'b0; step(4);
    expect_now("R6 ri leading", 8'h01, 8'h50);
    ri_n = 1'b1; step(4);
    expect_now("R6 ri trailing", 8'h00, 8'h14);
    strobe(6'b000001, 4'h0);
    dsr_n = 1'b0; cd_n = 1'b0; step(4);
    expect_now("R5 dsr cd", 8'h00, 8'hBA);
    strobe(6'b000001, 4'h0);
    expect_now("R7 read clears 2", 8'h01, 8'hB0);
    cts_n = 1'b1; dsr_n = 1'b1; cd_n = 1'b1; step(4);
    expect_now("R5 release", 8'h00, 8'h0B);
    strobe(6'b000001, 4'h0);

    // loopback
    ier = 4'h0;
    mcr = 5'b10010; step(2);
    expect_now("R4 loop rts", 8'h01, 8'h11);
    strobe(6'b000001, 4'h0);
    mcr = 5'b11111; step(2);
    expect_now("R4 R2 loop all", 8'h01, 8'hFA);
    mcr = 5'b10000; step(2);
    expect_now("R4 R6 loop drop", 8'h01, 8'h0F);
    strobe(6'b000001, 4'h0);
    mcr = '0; step(4);
    strobe(6'b000001, 4'h0);
    expect_now("R7 idle", 8'h01, 8'h00);

    // line and receive sources
    ier = 4'hF;
    strobe(6'b100000, 4'b0100);
    expect_now("R8 R12 line over rx", 8'h06, 8'h00);
    strobe(6'b000010, 4'h0);
    expect_now("R8 R9 line cleared", 8'h04, 8'h00);
    strobe(6'b000100, 4'h0);
    expect_now("R9 rx cleared", 8'h01, 8'h00);

    // transmit source
    thr_empty = 1'b1; step(1);
    expect_now("R10 tx empty", 8'h02, 8'h00);
    thr_empty = 1'b0;
    strobe(6'b010000, 4'h0);
    expect_now("R10 thr write", 8'h01, 8'h00);
    thr_empty = 1'b1; step(1);
    strobe(6'b001000, 4'h0);
    expect_now("R10 iir read", 8'h01, 8'h00);
    ier = 4'hD; step(1);
    ier = 4'hF; step(1);
    expect_now("R11 enable while empty", 8'h02, 8'h00);
    strobe(6'b100000, 4'h0);
    expect_now("R12 rx over tx", 8'h04, 8'h00);
    strobe(6'b001000, 4'h0);
    expect_now("R10 iir read other source", 8'h04, 8'h00);
    strobe(6'b000100, 4'h0);
    expect_now("R10 tx kept", 8'h02, 8'h00);
    cts_n = 1'b0; step(4);
    expect_now("R12 tx over modem", 8'h02, 8'h11);
    thr_empty = 1'b0;
    strobe(6'b010000, 4'h0);
    expect_now("R12 modem exposed", 8'h00, 8'h11);
    strobe(6'b000001, 4'h0);
    expect_now("R7 modem cleared", 8'h01, 8'h10);

    // masked line source
    ier = 4'h0;
    cts_n = 1'b1; step(4);
    strobe(6'b000001, 4'h0);
    strobe(6'b000000, 4'b1000);
    expect_now("R13 masked line", 8'h01, 8'h00);
    ier = 4'h4; step(1);
    expect_now("R13 unmasked line", 8'h06, 8'h00);
    strobe(6'b000010, 4'h0);
    expect_now("R8 line cleared", 8'h01, 8'h00);

    step(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule